// File: doc/BRIEF.md
# Scoreboarded Issue and Writeback Control

This block decides, once per cycle, whether the instruction waiting at the issue stage of a single-issue, in-order 64-bit integer pipeline may go. It also arbitrates the single register-file write port. Loads and long-latency function-unit operations do not hold the pipeline when they issue. Instead, each marks its destination register as pending in a table with one bit per architectural register per hardware thread. That bit stays set until the result arrives on the write port. A later instruction waits only if it reads or overwrites a register that is still pending. As a result, a run of independent loads, such as a function epilogue restoring saved registers, goes out at one per cycle. Function-unit results may also return in any order.

Plain ALU operations are not tracked in the table. The ALU needs two cycles to produce a result, so a small two-state machine remembers the destination of an ALU operation issued in the previous cycle. An instruction that reads that register right away is held for one cycle. The state `ST_CLEAR` means no ALU result is in flight. `ST_ALU_FRESH` means an ALU operation with a live destination issued in the previous cycle. The machine takes the transition `CLEAR->FRESH` when such an ALU op issues. It takes `FRESH->FRESH` when another one issues straight after. It takes `FRESH->CLEAR` in any other cycle.

Three sources compete for the write port: the memory port (loads), the shared function units and the ALU. They are served in that fixed order. A source that is not granted keeps presenting its result until it is. When a pending result is written, the pending bit drops in that same cycle. The instruction at issue may then go and receives the value through a forwarding flag.

Top module: `sb_issue_ctl`

## Requirements
- R1: `id_kind` encodes 0 = ALU, 1 = load, 2 = function unit, 3 = no result. A load or function-unit op issues without waiting for its own result and marks its destination pending. An instruction whose enabled source is pending is stalled (`id_issue`=0, `id_stall`=1). With `id_valid`=0 both outputs are 0.
- R2: Loads with distinct destinations and no pending sources issue on consecutive cycles, one per cycle.
- R3: Function-unit results may arrive in any order. Each result clears only the register named by its own tag, leaving other pending registers pending.
- R4: An instruction that reads the destination of an ALU op issued in the immediately preceding cycle stalls exactly one cycle. It issues the cycle after.
- R5: With two threads, each thread has its own 32 pending bits. A tag is {thread, register}, with the thread in the top bit. A pending register of one thread never stalls the other thread.
- R6: Register 0 is never marked pending. A load to register 0 followed by a read of register 0 issues without stall.
- R7: An instruction whose destination is still pending stalls until that result is written.
- R8: Write port priority is load, then function unit, then ALU, with at most one grant per cycle. A source that is not granted keeps its register pending until it is granted.
- R9: A pending bit clears in the cycle its result is written. An instruction waiting on it issues in that same cycle, and `id_fwd_rs1`/`id_fwd_rs2` flag a source that matches the written tag.
- R10: After reset no register is pending, no ALU result is in flight, and the write port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | An instruction is waiting at issue |
| id_thr | input | 1 | Thread of the instruction |
| id_kind | input | 2 | Latency class (0 ALU, 1 load, 2 function unit, 3 none) |
| id_rs1 | input | 5 | First source register |
| id_rs1_en | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source register |
| id_rs2_en | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register |
| id_rd_en | input | 1 | Destination is written |
| id_issue | output | 1 | Instruction issues this cycle |
| id_stall | output | 1 | Instruction is held this cycle |
| id_fwd_rs1 | output | 1 | First source takes the value on the write port |
| id_fwd_rs2 | output | 1 | Second source takes the value on the write port |
| ld_wb_valid | input | 1 | Load result present |
| ld_wb_tag | input | 6 | Load result tag {thread, register} |
| ld_wb_data | input | 64 | Load result value |
| ld_wb_grant | output | 1 | Load result written this cycle |
| fu_wb_valid | input | 1 | Function-unit result present |
| fu_wb_tag | input | 6 | Function-unit result tag |
| fu_wb_data | input | 64 | Function-unit result value |
| fu_wb_grant | output | 1 | Function-unit result written this cycle |
| alu_wb_valid | input | 1 | ALU result present |
| alu_wb_tag | input | 6 | ALU result tag |
| alu_wb_data | input | 64 | ALU result value |
| alu_wb_grant | output | 1 | ALU result written this cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 6 | Register-file write tag |
| rf_wdata | output | 64 | Register-file write value |

## Verification
The assertions check several properties on every cycle:
- a granted issue of a long-latency op always leaves its register pending on the next cycle;
- a write always clears it;
- register 0 of each thread never turns pending;
- the write port never grants two sources, and a load or function unit is never passed over by a lower-priority source;
- the ALU tracking state follows each cycle's issue.

Only the bench's scenarios can show the end-to-end orderings. These are loads leaving back to back, results returning younger-first, the single-cycle ALU bubble, isolation between threads, and a stalled instruction leaving in the very cycle its operand is written.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_LOAD = 2'd1,
        OP_FUNC = 2'd2,
        OP_NONE = 2'd3
    } op_kind_e;

    typedef enum logic {
        ST_CLEAR     = 1'b0,
        ST_ALU_FRESH = 1'b1
    } haz_state_e;

endpackage

// File: rtl/sb_busy_table.sv
module sb_busy_table #(
    parameter int NENT = 64,
    parameter int RW   = 5,
    localparam int TAGW = $clog2(NENT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [TAGW-1:0] set_tag,
    input  logic            clr_en,
    input  logic [TAGW-1:0] clr_tag,
    input  logic [TAGW-1:0] rd_a_tag,
    input  logic [TAGW-1:0] rd_b_tag,
    input  logic [TAGW-1:0] rd_c_tag,
    output logic            rd_a_busy,
    output logic            rd_b_busy,
    output logic            rd_c_busy
);

    logic [NENT-1:0] busy_q;
    logic [NENT-1:0] clr_vec;
    logic [NENT-1:0] busy_eff;
    logic            set_ok;

    // register zero of any thread is never tracked
    assign set_ok = set_en && (set_tag[RW-1:0] != '0);

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        assign clr_vec[e] = clr_en && (clr_tag == TAGW'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy_q[e] <= 1'b0;
            end else if (set_ok && (set_tag == TAGW'(e))) begin
                busy_q[e] <= 1'b1;
            end else if (clr_vec[e]) begin
                busy_q[e] <= 1'b0;
            end
        end
    end

    // a result being written this cycle no longer blocks anyone
    assign busy_eff  = busy_q & ~clr_vec;
    assign rd_a_busy = busy_eff[rd_a_tag];
    assign rd_b_busy = busy_eff[rd_b_tag];
    assign rd_c_busy = busy_eff[rd_c_tag];

    AST_SET_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) set_ok |=> busy_q[$past(set_tag)]); // R1
    AST_WB_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (clr_en && !(set_ok && set_tag == clr_tag)) |=> !busy_q[$past(clr_tag)]); // R9

    for (genvar t = 0; t < (NENT >> RW); t++) begin : g_zero
        AST_ZERO_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !busy_q[t << RW]); // R6
    end

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int XLEN = 64,
    parameter int TAGW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_v,
    input  logic [TAGW-1:0] ld_tag,
    input  logic [XLEN-1:0] ld_data,
    input  logic            fu_v,
    input  logic [TAGW-1:0] fu_tag,
    input  logic [XLEN-1:0] fu_data,
    input  logic            alu_v,
    input  logic [TAGW-1:0] alu_tag,
    input  logic [XLEN-1:0] alu_data,
    output logic            ld_g,
    output logic            fu_g,
    output logic            alu_g,
    output logic            we,
    output logic [TAGW-1:0] waddr,
    output logic [XLEN-1:0] wdata
);

    always_comb begin
        ld_g  = 1'b0;
        fu_g  = 1'b0;
        alu_g = 1'b0;
        waddr = '0;
        wdata = '0;
        if (ld_v) begin
            ld_g  = 1'b1;
            waddr = ld_tag;
            wdata = ld_data;
        end else if (fu_v) begin
            fu_g  = 1'b1;
            waddr = fu_tag;
            wdata = fu_data;
        end else if (alu_v) begin
            alu_g = 1'b1;
            waddr = alu_tag;
            wdata = alu_data;
        end
    end

    assign we = ld_g || fu_g || alu_g;

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ld_g, fu_g, alu_g})); // R8
    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ld_v |-> ld_g); // R8
    AST_FU_OVER_ALU: assert property (@(posedge clk) disable iff (!rst_n) (fu_v && !ld_v) |-> fu_g); // R8

endmodule

// File: rtl/sb_alu_hazard.sv
module sb_alu_hazard
    import sb_pkg::*;
#(
    parameter int TAGW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [1:0]      kind,
    input  logic [TAGW-1:0] rd_tag,
    input  logic            rd_live,
    input  logic [TAGW-1:0] src_a_tag,
    input  logic            src_a_live,
    input  logic [TAGW-1:0] src_b_tag,
    input  logic            src_b_live,
    output logic            src_a_hit,
    output logic            src_b_hit
);

    haz_state_e      state_q, state_d;
    logic [TAGW-1:0] pend_q;
    logic            alu_wr;

    assign alu_wr = issue && (op_kind_e'(kind) == OP_ALU) && rd_live;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:     if (alu_wr)  state_d = ST_ALU_FRESH;
            ST_ALU_FRESH: if (!alu_wr) state_d = ST_CLEAR;
            default:      state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (alu_wr) pend_q <= rd_tag;
        end
    end

    always_comb begin
        src_a_hit = (state_q == ST_ALU_FRESH) && src_a_live && (src_a_tag == pend_q);
        src_b_hit = (state_q == ST_ALU_FRESH) && src_b_live && (src_b_tag == pend_q);
    end

    AST_FRESH_AFTER_ALU: assert property (@(posedge clk) disable iff (!rst_n) alu_wr |=> state_q == ST_ALU_FRESH); // R4
    AST_CLEAR_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n) !alu_wr |=> state_q == ST_CLEAR); // R4

endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NREG    = 32,
    parameter int THREADS = 2,
    localparam int RW   = $clog2(NREG),
    localparam int TW   = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int TAGW = TW + RW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic [TW-1:0]   id_thr,
    input  logic [1:0]      id_kind,
    input  logic [RW-1:0]   id_rs1,
    input  logic            id_rs1_en,
    input  logic [RW-1:0]   id_rs2,
    input  logic            id_rs2_en,
    input  logic [RW-1:0]   id_rd,
    input  logic            id_rd_en,
    output logic            id_issue,
    output logic            id_stall,
    output logic            id_fwd_rs1,
    output logic            id_fwd_rs2,
    input  logic            ld_wb_valid,
    input  logic [TAGW-1:0] ld_wb_tag,
    input  logic [XLEN-1:0] ld_wb_data,
    output logic            ld_wb_grant,
    input  logic            fu_wb_valid,
    input  logic [TAGW-1:0] fu_wb_tag,
    input  logic [XLEN-1:0] fu_wb_data,
    output logic            fu_wb_grant,
    input  logic            alu_wb_valid,
    input  logic [TAGW-1:0] alu_wb_tag,
    input  logic [XLEN-1:0] alu_wb_data,
    output logic            alu_wb_grant,
    output logic            rf_we,
    output logic [TAGW-1:0] rf_waddr,
    output logic [XLEN-1:0] rf_wdata
);

    localparam int NENT = (2 ** TW) * NREG;

    logic [TW-1:0]   thr_eff;
    logic [TAGW-1:0] tag_a, tag_b, tag_d, clr_tag;
    logic            live_a, live_b, live_d, long_op;
    logic            busy_a, busy_b, busy_d, alu_a, alu_b;
    logic            hazard, set_en, clr_en;

    assign thr_eff = (THREADS > 1) ? id_thr : '0;
    assign tag_a   = {thr_eff, id_rs1};
    assign tag_b   = {thr_eff, id_rs2};
    assign tag_d   = {thr_eff, id_rd};
    assign live_a  = id_rs1_en && (id_rs1 != '0);
    assign live_b  = id_rs2_en && (id_rs2 != '0);
    assign live_d  = id_rd_en && (id_rd != '0);
    assign long_op = (op_kind_e'(id_kind) == OP_LOAD) || (op_kind_e'(id_kind) == OP_FUNC);

    sb_wb_arbiter #(.XLEN(XLEN), .TAGW(TAGW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_v     (ld_wb_valid),
        .ld_tag   (ld_wb_tag),
        .ld_data  (ld_wb_data),
        .fu_v     (fu_wb_valid),
        .fu_tag   (fu_wb_tag),
        .fu_data  (fu_wb_data),
        .alu_v    (alu_wb_valid),
        .alu_tag  (alu_wb_tag),
        .alu_data (alu_wb_data),
        .ld_g     (ld_wb_grant),
        .fu_g     (fu_wb_grant),
        .alu_g    (alu_wb_grant),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata)
    );

    assign clr_en  = ld_wb_grant || fu_wb_grant;
    assign clr_tag = ld_wb_grant ? ld_wb_tag : fu_wb_tag;

    sb_busy_table #(.NENT(NENT), .RW(RW)) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en),
        .set_tag   (tag_d),
        .clr_en    (clr_en),
        .clr_tag   (clr_tag),
        .rd_a_tag  (tag_a),
        .rd_b_tag  (tag_b),
        .rd_c_tag  (tag_d),
        .rd_a_busy (busy_a),
        .rd_b_busy (busy_b),
        .rd_c_busy (busy_d)
    );

    sb_alu_hazard #(.TAGW(TAGW)) u_alu_haz (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (id_issue),
        .kind       (id_kind),
        .rd_tag     (tag_d),
        .rd_live    (live_d),
        .src_a_tag  (tag_a),
        .src_a_live (live_a),
        .src_b_tag  (tag_b),
        .src_b_live (live_b),
        .src_a_hit  (alu_a),
        .src_b_hit  (alu_b)
    );

    // read-after-write on a pending source, write-after-write on a pending
    // destination, or a source produced by the ALU one cycle ago
    assign hazard = (live_a && busy_a) || (live_b && busy_b) || (live_d && busy_d) || alu_a || alu_b;

    assign id_issue = id_valid && !hazard;
    assign id_stall = id_valid && hazard;
    assign set_en   = id_issue && long_op && live_d;

    assign id_fwd_rs1 = rf_we && live_a && (rf_waddr == tag_a);
    assign id_fwd_rs2 = rf_we && live_b && (rf_waddr == tag_b);

endmodule

// File: tb/sb_issue_ctl_test.sv
`timescale 1ns/1ps
module sb_issue_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid;
    logic [0:0]  id_thr;
    logic [1:0]  id_kind;
    logic [4:0]  id_rs1, id_rs2, id_rd;
    logic        id_rs1_en, id_rs2_en, id_rd_en;
    logic        id_issue, id_stall, id_fwd_rs1, id_fwd_rs2;
    logic        ld_wb_valid, fu_wb_valid, alu_wb_valid;
    logic [5:0]  ld_wb_tag, fu_wb_tag, alu_wb_tag;
    logic [63:0] ld_wb_data, fu_wb_data, alu_wb_data;
    logic        ld_wb_grant, fu_wb_grant, alu_wb_grant;
    logic        rf_we;
    logic [5:0]  rf_waddr;
    logic [63:0] rf_wdata;

    sb_issue_ctl uut (.*);

    always #2 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    bit          busy_m [64];
    int          ld_cnt [64];
    int          fu_cnt [64];
    bit          fresh_m;
    logic [5:0]  last_m;
    bit          last_haz;
    bit          fu_held;
    logic [5:0]  fu_cur;
    logic [63:0] fu_dat;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic ins(input bit v, input bit th, input int k, input int s1, input bit e1,
                       input int s2, input bit e2, input int d, input bit ed);
        id_valid = v; id_thr = th; id_kind = 2'(k);
        id_rs1 = 5'(s1); id_rs1_en = e1;
        id_rs2 = 5'(s2); id_rs2_en = e2;
        id_rd = 5'(d); id_rd_en = ed;
    endtask

    task automatic wb(input bit lv, input int lt, input bit fv, input int ft, input bit av, input int at);
        ld_wb_valid = lv;  ld_wb_tag = 6'(lt);  ld_wb_data = {$urandom, $urandom};
        fu_wb_valid = fv;  fu_wb_tag = 6'(ft);  fu_wb_data = {$urandom, $urandom};
        alu_wb_valid = av; alu_wb_tag = 6'(at); alu_wb_data = {$urandom, $urandom};
    endtask

    // one cycle: inputs are set at the falling edge, outputs compared just after
    task automatic tick(input string note, input int exp_issue);
        bit lg, fg, ag, we, clr, u1, u2, ud, haz, go;
        logic [5:0]  wa, ct, t1, t2, td;
        logic [63:0] wd;
        #1;
        lg  = ld_wb_valid;
        fg  = fu_wb_valid && !lg;
        ag  = alu_wb_valid && !lg && !fu_wb_valid;
        we  = lg || fg || ag;
        wa  = lg ? ld_wb_tag : (fg ? fu_wb_tag : alu_wb_tag);
        wd  = lg ? ld_wb_data : (fg ? fu_wb_data : alu_wb_data);
        clr = lg || fg;
        ct  = lg ? ld_wb_tag : fu_wb_tag;
        t1  = {id_thr, id_rs1};
        t2  = {id_thr, id_rs2};
        td  = {id_thr, id_rd};
        u1  = id_rs1_en && (id_rs1 != 0);
        u2  = id_rs2_en && (id_rs2 != 0);
        ud  = id_rd_en && (id_rd != 0);
        haz = (u1 && busy_m[t1] && !(clr && ct == t1)) ||
              (u2 && busy_m[t2] && !(clr && ct == t2)) ||
              (ud && busy_m[td] && !(clr && ct == td)) ||
              (fresh_m && ((u1 && t1 == last_m) || (u2 && t2 == last_m)));
        go  = id_valid && !haz;

        chk("R8 load grant", 64'(ld_wb_grant), 64'(lg));
        chk("R8 function-unit grant", 64'(fu_wb_grant), 64'(fg));
        chk("R8 ALU grant", 64'(alu_wb_grant), 64'(ag));
        chk("R8 write enable", 64'(rf_we), 64'(we));
        if (we) begin
            chk("R8 write tag", 64'(rf_waddr), 64'(wa));
            chk("R8 write data", rf_wdata, wd);
        end
        chk("R1/R7 issue decision", 64'(id_issue), 64'(go));
        chk("R1 stall flag", 64'(id_stall), 64'(id_valid && haz));
        chk("R9 forward rs1", 64'(id_fwd_rs1), 64'(we && u1 && wa == t1));
        chk("R9 forward rs2", 64'(id_fwd_rs2), 64'(we && u2 && wa == t2));
        if (exp_issue >= 0) chk(note, 64'(id_issue), 64'(exp_issue));

        @(posedge clk);
        if (clr) begin
            busy_m[ct] = 0;
            if (lg) ld_cnt[ct] = -1;
            else begin
                fu_cnt[ct] = -1;
                fu_held = 0;
            end
        end
        for (int e = 0; e < 64; e++) begin
            if (ld_cnt[e] > 0) ld_cnt[e]--;
            if (fu_cnt[e] > 0) fu_cnt[e]--;
        end
        if (go && (id_kind == 2'd1 || id_kind == 2'd2) && ud) begin
            busy_m[td] = 1;
            if (id_kind == 2'd1) ld_cnt[td] = 6;
            else fu_cnt[td] = 1 + int'($urandom_range(7));
        end
        fresh_m  = go && (id_kind == 2'd0) && ud;
        last_m   = td;
        last_haz = id_valid && haz;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int e = 0; e < 64; e++) begin
            busy_m[e] = 0; ld_cnt[e] = -1; fu_cnt[e] = -1;
        end
        fresh_m = 0; last_m = '0; last_haz = 0; fu_held = 0; fu_cur = '0; fu_dat = '0;
        rst_n = 1'b0;
        ins(0, 0, 3, 0, 0, 0, 0, 0, 0);
        wb(0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        tick("R10 idle after reset", 0);
        ins(1, 0, 0, 1, 1, 2, 1, 3, 1);
        tick("R10 nothing pending after reset", 1);

        // R2: four independent loads back to back
        for (int i = 0; i < 4; i++) begin
            ins(1, 0, 1, 2, 1, 0, 0, 10 + i, 1);
            tick("R2 back-to-back load issue", 1);
        end

        // R1 / R9: use of a pending load result
        ins(1, 0, 0, 10, 1, 0, 0, 20, 1);
        tick("R1 read of pending register stalls", 0);
        tick("R1 still pending", 0);
        wb(1, 10, 0, 0, 0, 0);
        tick("R9 issue in writeback cycle", 1);

        // R4: single-cycle ALU bubble
        wb(0, 0, 0, 0, 0, 0);
        ins(1, 0, 0, 20, 1, 0, 0, 21, 1);
        tick("R4 stall right after ALU producer", 0);
        tick("R4 issue one cycle later", 1);
        ins(0, 0, 3, 0, 0, 0, 0, 0, 0);
        for (int i = 11; i < 14; i++) begin
            wb(1, i, 0, 0, 0, 0);
            tick("R3 drain loads", -1);
        end
        wb(0, 0, 0, 0, 0, 0);

        // R6: register zero
        ins(1, 0, 1, 1, 1, 0, 0, 0, 1);
        tick("R6 load to register zero", 1);
        ins(1, 0, 0, 0, 1, 0, 1, 22, 1);
        tick("R6 register zero never pending", 1);

        // R7: pending destination
        ins(1, 0, 2, 1, 1, 0, 0, 5, 1);
        tick("R3 function-unit op issues", 1);
        ins(1, 0, 0, 0, 0, 0, 0, 5, 1);
        tick("R7 pending destination stalls", 0);
        wb(0, 0, 1, 5, 0, 0);
        tick("R7 issue once result lands", 1);
        wb(0, 0, 0, 0, 0, 0);

        // R5: thread isolation
        ins(1, 0, 1, 1, 1, 0, 0, 6, 1);
        tick("R1 load issues without stall", 1);
        ins(1, 1, 0, 6, 1, 0, 0, 23, 1);
        tick("R5 other thread unaffected", 1);
        ins(1, 0, 0, 6, 1, 0, 0, 23, 1);
        tick("R5 own thread stalls", 0);
        ins(0, 0, 3, 0, 0, 0, 0, 0, 0);
        wb(1, 6, 0, 0, 0, 0);
        tick("R5 drain", -1);
        wb(0, 0, 0, 0, 0, 0);

        // R3: out-of-order function-unit completion
        ins(1, 0, 2, 0, 0, 0, 0, 7, 1);
        tick("R3 first function-unit op", 1);
        ins(1, 0, 2, 0, 0, 0, 0, 8, 1);
        tick("R3 second function-unit op", 1);
        wb(0, 0, 1, 8, 0, 0);
        ins(1, 0, 0, 8, 1, 0, 0, 24, 1);
        tick("R3 younger result completes first", 1);
        wb(0, 0, 0, 0, 0, 0);
        ins(1, 0, 0, 7, 1, 0, 0, 25, 1);
        tick("R3 older op still pending", 0);
        wb(0, 0, 1, 7, 0, 0);
        tick("R3 older result completes", 1);
        wb(0, 0, 0, 0, 0, 0);

        // R8: three results at once
        ins(1, 0, 1, 0, 0, 0, 0, 9, 1);
        tick("R8 setup load", 1);
        ins(1, 0, 2, 0, 0, 0, 0, 14, 1);
        tick("R8 setup function-unit op", 1);
        wb(1, 9, 1, 14, 1, 15);
        ins(1, 0, 0, 14, 1, 0, 0, 26, 1);
        tick("R8 held function unit keeps register pending", 0);
        wb(0, 0, 1, 14, 1, 15);
        tick("R8 function unit before ALU", 1);
        wb(0, 0, 0, 0, 1, 15);
        ins(0, 0, 3, 0, 0, 0, 0, 0, 0);
        tick("R8 ALU granted last", -1);

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            ld_wb_valid = 0; ld_wb_tag = '0; ld_wb_data = {$urandom, $urandom};
            for (int e = 0; e < 64; e++)
                if (!ld_wb_valid && ld_cnt[e] == 0) begin
                    ld_wb_valid = 1; ld_wb_tag = 6'(e);
                end
            if (!fu_held)
                for (int e = 0; e < 64; e++)
                    if (!fu_held && fu_cnt[e] == 0) begin
                        fu_held = 1; fu_cur = 6'(e); fu_dat = {$urandom, $urandom};
                    end
            fu_wb_valid  = fu_held; fu_wb_tag = fu_cur; fu_wb_data = fu_dat;
            alu_wb_valid = ($urandom_range(9) < 3);
            alu_wb_tag   = 6'($urandom_range(63));
            alu_wb_data  = {$urandom, $urandom};
            if (!last_haz) begin
                id_valid  = ($urandom_range(9) < 8);
                id_thr    = 1'($urandom_range(1));
                id_kind   = 2'($urandom_range(3));
                id_rs1    = 5'($urandom_range(7));
                id_rs2    = 5'($urandom_range(7));
                id_rd     = 5'($urandom_range(7));
                id_rs1_en = 1'($urandom_range(1));
                id_rs2_en = 1'($urandom_range(1));
                id_rd_en  = (id_kind == 2'd1 || id_kind == 2'd2) ? 1'b1 : 1'($urandom_range(1));
            end
            tick("R1/R8 random traffic", -1);
        end

        done = 1;
        report();
    end

endmodule